// File: doc/BRIEF.md
# Sound-Chip Bus Control Sequencer

This block connects a general-purpose output port to the bus of a sound generator. The sound generator has sixteen byte-wide internal registers. Two bits of the port byte form an operation code. Each cycle the code selects one of four actions on the shared data byte: leave the bus alone, place the selected register on the bus, store the bus value into the selected register, or take the bus value as the new register number. The block contains the sixteen-entry register file itself, so the whole handshake can be checked without the tone or audio logic.

The shared byte is split at the pad into an input value, an output value and an output enable. The output enable is high only for the read code, which lets the outside port know when it must release the line. Store and address operations are gated on a stable code. An action commits at the clock edge that closes a cycle whose code matches the code of the cycle before. A code that lasts a single cycle while the controlling software changes the port bits therefore has no effect.

Top module: `sndbus_ctrl`

## Requirements
- R1: The operation code is port bits 7 (direction bit) and 6 (mode bit). Port bits 5 to 0 have no effect on any output or stored value.
- R2: Code 00 is idle. `bus_oe` is low, `bus_out` is 0, and no register or select state changes.
- R3: Code 01 is read. `bus_oe` is high in the same cycle, and `bus_out` shows the register named by the current select.
- R4: Code 10 is write. The `bus_in` value is stored into the selected register.
- R5: Code 11 is address latch. `bus_in` bits 3:0 become the register select.
- R6: If an address latch sees a nonzero value in `bus_in` bits 7:4, the select is marked invalid. While it is invalid, a read returns 0xFF.
- R7: While the select is invalid, writes change no register. A later latch with bits 7:4 equal to zero makes the select valid again.
- R8: A write or latch commits only at a clock edge that ends a cycle whose code equals the code of the previous cycle. A write or latch code that is present for one cycle only does nothing.
- R9: The synchronous active-low reset clears all sixteen registers to 0 and sets the select to register 0, marked valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_port | input | 8 | Output-port byte; bits 7:6 carry the operation code |
| bus_in | input | 8 | Value present on the shared data byte |
| bus_out | output | 8 | Value the block drives onto the shared byte |
| bus_oe | output | 1 | High while the block drives the shared byte |

## Verification
A write commit and a read drive can fall on neighbouring sides of one clock edge. This happens when the code moves straight from write to read: the edge that ends the last write cycle stores the byte, and the read in the very next cycle must already return it. The bench provokes this with back-to-back write-then-read sequences that have no idle cycle between them, and with latch-then-read sequences. It judges the result with a scoreboard whose expected bytes come from a register model. The model advances only when a code has been held for two cycles. A single-cycle write code placed right before a read checks the opposite case, where nothing may be stored.

// File: rtl/sndbus_pkg.sv
// Package: shared operation code type for the sound-bus sequencer.
// Assumes the code is two bits: direction bit above mode bit.
package sndbus_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_READ  = 2'b01,
        OP_WRITE = 2'b10,
        OP_LATCH = 2'b11
    } bus_op_e;
endpackage

// File: rtl/sndbus_decode.sv
// Module: extracts the operation code from the port byte and flags a
// commit when a store-type code has been held for two sampled cycles.
// Assumes synchronous active-low reset; other port bits are ignored.
module sndbus_decode
    import sndbus_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int CODE_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] ctl_port,
    output bus_op_e           op_now,
    output logic              commit
);
    localparam int CODE_MSB = CODE_LSB + 1;

    bus_op_e op_q;
    logic    unused_port_bits;

    // Current code taken straight from the port bits.
    assign op_now = bus_op_e'(ctl_port[CODE_MSB:CODE_LSB]);

    // Remaining port bits belong to other functions.
    assign unused_port_bits = ^{ctl_port[CODE_LSB-1:0]} ^
                              ((CODE_MSB < PORT_W - 1) ? ^ctl_port : 1'b0);

    // Remember the previous cycle's code for the stability test.
    always_ff @(posedge clk) begin
        if (!rst_n) op_q <= OP_IDLE;
        else        op_q <= op_now;
    end

    // Store-type codes (direction bit set) commit once stable.
    assign commit = op_now[1] && (op_now == op_q);

    AST_COMMIT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (op_now == $past(op_now)));  // R8
endmodule

// File: rtl/sndbus_select.sv
// Module: holds the register select and its validity flag.
// Assumes a latch request only arrives on a committed address code.
module sndbus_select #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [DATA_W-1:0] din,
    output logic [ADDR_W-1:0] sel_q,
    output logic              sel_ok
);
    logic upper_clear;

    // Validity: the bits above the address field must be zero.
    assign upper_clear = (din[DATA_W-1:ADDR_W] == '0);

    // Capture select and validity on a committed latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            sel_ok <= 1'b1;
        end else if (latch_en) begin
            sel_q  <= din[ADDR_W-1:0];
            sel_ok <= upper_clear;
        end
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> ($stable(sel_q) && $stable(sel_ok)));  // R5
    AST_SEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |=> (sel_q == $past(din[ADDR_W-1:0])));  // R5
    AST_BAD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_en && (din[DATA_W-1:ADDR_W] != '0)) |=> !sel_ok);  // R6
endmodule

// File: rtl/sndbus_regfile.sv
// Module: sixteen-entry (by default) byte register file, one write port,
// one asynchronous read port. Assumes wr_en already qualified.
module sndbus_regfile #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        // One storage entry, cleared by reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                mem[i] <= '0;
            else if (wr_en && (addr == ADDR_W'(i)))    mem[i] <= wdata;
        end
    end

    // Read port follows the address combinationally.
    assign rdata = mem[addr];

    AST_WR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(addr)] == $past(wdata)));  // R4
endmodule

// File: rtl/sndbus_ctrl.sv
// Module: top of the sound-bus sequencer. Decodes the port code, routes
// writes and latches, and drives the shared byte only for the read code.
// Assumes the shared byte is split into in/out/enable at the pad.
module sndbus_ctrl
    import sndbus_pkg::*;
#(
    parameter int PORT_W   = 8,
    parameter int CODE_LSB = 6,
    parameter int DATA_W   = 8,
    parameter int ADDR_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] ctl_port,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe
);
    localparam int CODE_MSB = CODE_LSB + 1;

    bus_op_e           op_now;
    logic              commit;
    logic              latch_en;
    logic              wr_en;
    logic [ADDR_W-1:0] sel_q;
    logic              sel_ok;
    logic [DATA_W-1:0] rdata;

    sndbus_decode #(.PORT_W(PORT_W), .CODE_LSB(CODE_LSB)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl_port (ctl_port),
        .op_now   (op_now),
        .commit   (commit)
    );

    // Route a committed code to the select latch or the register file.
    assign latch_en = commit && (op_now == OP_LATCH);
    assign wr_en    = commit && (op_now == OP_WRITE) && sel_ok;

    sndbus_select #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_select (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .din      (bus_in),
        .sel_q    (sel_q),
        .sel_ok   (sel_ok)
    );

    sndbus_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regfile (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (sel_q),
        .wdata (bus_in),
        .rdata (rdata)
    );

    // Drive the shared byte only for the read code; all ones if invalid.
    always_comb begin
        bus_oe  = (op_now == OP_READ);
        bus_out = '0;
        if (bus_oe) bus_out = sel_ok ? rdata : '1;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_port[CODE_MSB:CODE_LSB] == 2'b00) |-> !bus_oe);  // R2
    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_port[CODE_MSB:CODE_LSB] == 2'b01) |-> bus_oe);  // R3
    AST_NO_WRITE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && ctl_port[CODE_MSB]) |=> $stable(rdata) || $past(latch_en));  // R7
endmodule

// File: tb/tb_sndbus_ctrl.sv
// Bench: scoreboard of expected read bytes from a register model.
module tb_sndbus_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ctl_port = 8'h00;
    logic [7:0] bus_in = 8'h00;
    logic [7:0] bus_out;
    logic       bus_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] mdl [16];
    logic [3:0] msel;
    bit         mok;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    sndbus_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_port(ctl_port),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always #5 clk = ~clk;

    task automatic model_reset();
        for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
        msel = 4'd0;
        mok  = 1'b1;
    endtask

    // Apply one code with data for n cycles; low port bits are random (R1).
    task automatic drive(input logic [1:0] code, input logic [7:0] d, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            ctl_port = {code, 6'($urandom)};
            bus_in   = d;
        end
    endtask

    task automatic idle(input int n);
        drive(2'b00, 8'($urandom), n);  // R2: idle with arbitrary bus
    endtask

    task automatic latch(input logic [7:0] a);
        drive(2'b11, a, 2);
        msel = a[3:0];
        mok  = (a[7:4] == 4'h0);
    endtask

    task automatic write(input logic [7:0] d);
        drive(2'b10, d, 2);
        if (mok) mdl[msel] = d;
    endtask

    task automatic read(input string tag);
        exp_q.push_back(mok ? mdl[msel] : 8'hFF);
        tag_q.push_back(tag);
        drive(2'b01, 8'($urandom), 1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ctl_port = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: pops expected bytes whenever the block drives the bus.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && !done) begin
                if (bus_oe) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        fails++;
                        $display("FAIL R3 unexpected drive: got %02h expected no drive", bus_out);
                    end else begin
                        logic [7:0] e;
                        string t;
                        e = exp_q.pop_front();
                        t = tag_q.pop_front();
                        if (bus_out !== e) begin
                            fails++;
                            $display("FAIL %s: got %02h expected %02h", t, bus_out, e);
                        end
                    end
                end else if (ctl_port[7:6] != 2'b01) begin
                    if (bus_out !== 8'h00) begin
                        checks++;
                        fails++;
                        $display("FAIL R2 bus_out while not reading: got %02h expected 00", bus_out);
                    end
                end else begin
                    checks++;
                    fails++;
                    $display("FAIL R3 bus_oe low on read code: got 0 expected 1");
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        model_reset();
        do_reset();
        idle(2);

        // R9: after reset the select is register 0 and all entries clear.
        read("R9 reset select/reg0");
        for (int i = 0; i < 16; i++) begin
            idle(1);
            latch(8'(i));
            read("R9 reset entry");
        end

        // R4 R5: fill every register, then read each back.
        for (int i = 0; i < 16; i++) begin
            idle(1);
            latch(8'(i));
            idle(1);
            write(8'(8'h11 * i) ^ 8'hA5);
        end
        for (int i = 15; i >= 0; i--) begin
            idle(1);
            latch(8'(i));
            read("R5 latch then read");
        end

        // Write then read with no idle between (R4, same-cycle boundary).
        idle(1);
        latch(8'h07);
        write(8'h3C);
        read("R4 write then immediate read");
        write(8'hC3);
        read("R4 second write then read");

        // R2: long idle with busy data bus must not alter anything.
        idle(5);
        read("R2 idle leaves register");

        // R8: single-cycle write code must not store.
        idle(1);
        drive(2'b10, 8'hEE, 1);
        read("R8 one-cycle write ignored");
        // R8: single-cycle latch code must not move the select.
        idle(1);
        drive(2'b11, 8'h02, 1);
        read("R8 one-cycle latch ignored");
        // R8: write code changing from idle directly to latch for one cycle.
        idle(1);
        drive(2'b10, 8'h99, 1);
        drive(2'b11, 8'h01, 1);
        idle(1);
        read("R8 one-cycle codes in a row");

        // R6: invalid select reads all ones.
        idle(1);
        latch(8'h25);
        read("R6 invalid select reads FF");
        // R7: write ignored while invalid.
        idle(1);
        write(8'h77);
        idle(1);
        latch(8'h05);
        read("R7 write ignored while invalid");
        idle(1);
        latch(8'h80);
        write(8'h12);
        latch(8'h00);
        read("R7 reg0 untouched by invalid write");
        idle(1);
        write(8'h4D);
        read("R7 valid again after good latch");

        // R9: reset mid-run clears everything again.
        do_reset();
        idle(1);
        read("R9 second reset select");
        idle(1);
        latch(8'h07);
        read("R9 second reset reg7");

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R3 missing reads: got %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule